// File: doc/BRIEF.md
# Multicycle Register-File Processor Core

A compact 16-bit processor made of a state-machine controller and a datapath. The datapath holds a program counter, an instruction register, sixteen 16-bit general registers, an arithmetic unit that adds, subtracts or passes an operand and reports when its result is zero, and selectors for the register write source, the memory address and the store data. One word-wide memory port with a read strobe and a write strobe carries both instruction fetches and data accesses.

Seven instructions are decoded: load a register from a direct address, store a register to a direct address, store one register to the address held in another register, load an 8-bit immediate, add, subtract, and a relative branch taken when a register is zero. Every other opcode stops the core until the next reset. Memory returns read data one cycle after the address and read strobe are presented, so the core holds each read address for two cycles.

Top module: `tiny_cpu`

## Requirements
- R1: While rst_ni is low the PC is zero and neither memory strobe is active, and the first access after reset is an instruction read at address 0.
- R2: Each instruction starts with two read cycles at the PC holding the same address, then one idle decode cycle, and the PC advances by one as the instruction register is loaded.
- R3: The instruction word carries the opcode in bits 15..12, the first register rn in bits 11..8, the second register rm in bits 7..4 and an 8-bit address, immediate or offset in bits 7..0.
- R4: Opcode 0 reads memory for two cycles at the zero-extended 8-bit address and writes the returned word into rn.
- R5: Opcode 1 spends one cycle writing rn to the zero-extended 8-bit address; the next cycle is a fetch.
- R6: Opcode 2 spends one cycle writing rm to the address held in rn.
- R7: Opcode 3 loads rn with the 8-bit field zero-extended to 16 bits, with no memory access.
- R8: Opcode 4 sets rn to rn + rm and opcode 5 sets rn to rn - rm, both modulo 2^16.
- R9: Opcode 6 sets the PC to the incremented PC plus the sign-extended 8-bit offset when rn is zero, and otherwise leaves the incremented PC.
- R10: Opcodes 7 through 15 put the core in a stopped state in which halted_o stays high and no memory access is made until reset.
- R11: The read strobe and the write strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Word address of the memory access |
| mem_rd_o | output | 1 | Read strobe; data returns one cycle later |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 16 | Data written when mem_wr_o is high |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read strobe |
| halted_o | output | 1 | High once an unused opcode has been decoded |

## Verification
The controller state, PC and registers are hidden, but every one of them surfaces on the memory port within a few cycles. A wrong state or a missed PC increment shows up in the next fetch address, at most four cycles later; a wrong register value shows up as a wrong address or data on the next store that uses it, and a wrong branch decision moves every later fetch address. Comparing the port against a behavioural instruction model on every cycle therefore pins a fault to the first cycle in which it becomes visible.

// File: rtl/tiny_cpu_pkg.sv
package tiny_cpu_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned REG_W   = 4;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned NREGS   = 1 << REG_W;

  typedef enum logic [3:0] {
    OP_LOAD   = 4'h0,
    OP_STORE  = 4'h1,
    OP_STIND  = 4'h2,
    OP_IMM    = 4'h3,
    OP_ADD    = 4'h4,
    OP_SUB    = 4'h5,
    OP_JZ     = 4'h6
  } opcode_e;

  typedef enum logic [1:0] {
    RF_SRC_ALU = 2'b00,
    RF_SRC_MEM = 2'b01,
    RF_SRC_IMM = 2'b10
  } rf_src_e;

  typedef enum logic [1:0] {
    ADDR_RF  = 2'b00,
    ADDR_DIR = 2'b01,
    ADDR_PC  = 2'b10
  } addr_sel_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_PASS = 2'b10
  } alu_sel_e;

  typedef enum logic [3:0] {
    ST_RESET, ST_FETCH_A, ST_FETCH_B, ST_DECODE,
    ST_LOAD_A, ST_LOAD_B, ST_STORE, ST_STIND,
    ST_IMM, ST_ADD, ST_SUB, ST_JZ, ST_HALT
  } state_e;

  typedef struct packed {
    logic      ir_ld;
    logic      pc_clr;
    logic      pc_inc;
    logic      pc_ld;
    logic      mem_rd;
    logic      mem_wr;
    addr_sel_e addr_sel;
    rf_src_e   rf_src;
    logic      rf_we;
    logic      rf_r1_en;
    logic      rf_r2_en;
    alu_sel_e  alu_sel;
    logic      wd_from_r2;
  } ctrl_t;
endpackage

// File: rtl/tiny_cpu_alu.sv
module tiny_cpu_alu
  import tiny_cpu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_sel_e     sel_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (sel_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = a_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/tiny_cpu_rf.sv
module tiny_cpu_rf #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] r1_addr_i,
  input  logic          r1_en_i,
  output logic [W-1:0]  r1_data_o,
  input  logic [AW-1:0] r2_addr_i,
  input  logic          r2_en_i,
  output logic [W-1:0]  r2_data_o,
  input  logic [AW-1:0] w_addr_i,
  input  logic          w_en_i,
  input  logic [W-1:0]  w_data_i
);
  logic [W-1:0] regs_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (w_en_i) regs_q[w_addr_i] <= w_data_i;
  end

  assign r1_data_o = r1_en_i ? regs_q[r1_addr_i] : '0;
  assign r2_data_o = r2_en_i ? regs_q[r2_addr_i] : '0;
endmodule

// File: rtl/tiny_cpu_ctrl.sv
module tiny_cpu_ctrl
  import tiny_cpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            alu_zero_i,
  output ctrl_t           ctrl_o,
  output logic            halted_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:   state_d = ST_FETCH_A;
      ST_FETCH_A: state_d = ST_FETCH_B;
      ST_FETCH_B: state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (opcode_i)
          OP_LOAD:  state_d = ST_LOAD_A;
          OP_STORE: state_d = ST_STORE;
          OP_STIND: state_d = ST_STIND;
          OP_IMM:   state_d = ST_IMM;
          OP_ADD:   state_d = ST_ADD;
          OP_SUB:   state_d = ST_SUB;
          OP_JZ:    state_d = ST_JZ;
          default:  state_d = ST_HALT;
        endcase
      end
      ST_LOAD_A:  state_d = ST_LOAD_B;
      ST_HALT:    state_d = ST_HALT;
      default:    state_d = ST_FETCH_A;
    endcase
  end

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.addr_sel = ADDR_PC;
    ctrl_o.rf_src   = RF_SRC_ALU;
    ctrl_o.alu_sel  = ALU_PASS;
    unique case (state_q)
      ST_RESET: ctrl_o.pc_clr = 1'b1;
      ST_FETCH_A: ctrl_o.mem_rd = 1'b1;
      ST_FETCH_B: begin
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.ir_ld  = 1'b1;
        ctrl_o.pc_inc = 1'b1;
      end
      ST_LOAD_A: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = ADDR_DIR;
      end
      ST_LOAD_B: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = ADDR_DIR;
        ctrl_o.rf_we    = 1'b1;
        ctrl_o.rf_src   = RF_SRC_MEM;
      end
      ST_STORE: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = ADDR_DIR;
        ctrl_o.rf_r1_en = 1'b1;
      end
      ST_STIND: begin
        ctrl_o.mem_wr     = 1'b1;
        ctrl_o.addr_sel   = ADDR_RF;
        ctrl_o.rf_r1_en   = 1'b1;
        ctrl_o.rf_r2_en   = 1'b1;
        ctrl_o.wd_from_r2 = 1'b1;
      end
      ST_IMM: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.rf_src = RF_SRC_IMM;
      end
      ST_ADD, ST_SUB: begin
        ctrl_o.rf_we    = 1'b1;
        ctrl_o.rf_r1_en = 1'b1;
        ctrl_o.rf_r2_en = 1'b1;
        ctrl_o.alu_sel  = (state_q == ST_ADD) ? ALU_ADD : ALU_SUB;
      end
      ST_JZ: begin
        ctrl_o.rf_r1_en = 1'b1;
        ctrl_o.pc_ld    = alu_zero_i;
      end
      default: ;
    endcase
  end

  assign halted_o = (state_q == ST_HALT);
endmodule

// File: rtl/tiny_cpu.sv
module tiny_cpu
  import tiny_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o
);
  localparam int unsigned EXT_W = DATA_W - FIELD_W;

  ctrl_t              ctrl;
  logic [DATA_W-1:0]  pc_q, ir_q;
  logic [DATA_W-1:0]  r1_data, r2_data, alu_y, rf_wdata;
  logic               alu_zero, pc_inc;
  logic [OP_W-1:0]    f_op;
  logic [REG_W-1:0]   f_rn, f_rm;
  logic [FIELD_W-1:0] f_lit;
  logic [DATA_W-1:0]  lit_zx, lit_sx;

  // R3 field positions
  assign f_op   = ir_q[DATA_W-1 -: OP_W];
  assign f_rn   = ir_q[DATA_W-OP_W-1 -: REG_W];
  assign f_rm   = ir_q[FIELD_W-1 -: REG_W];
  assign f_lit  = ir_q[FIELD_W-1:0];
  assign lit_zx = {{EXT_W{1'b0}}, f_lit};
  assign lit_sx = {{EXT_W{f_lit[FIELD_W-1]}}, f_lit};
  assign pc_inc = ctrl.pc_inc;

  tiny_cpu_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opcode_i   (f_op),
    .alu_zero_i (alu_zero),
    .ctrl_o     (ctrl),
    .halted_o   (halted_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (ctrl.ir_ld) ir_q <= mem_rdata_i;
      if (ctrl.pc_clr)     pc_q <= '0;
      else if (ctrl.pc_ld) pc_q <= pc_q + lit_sx;
      else if (ctrl.pc_inc) pc_q <= pc_q + 1'b1;
    end
  end

  tiny_cpu_rf #(.W(DATA_W), .DEPTH(NREGS)) u_rf (
    .clk_i     (clk_i),
    .r1_addr_i (f_rn),
    .r1_en_i   (ctrl.rf_r1_en),
    .r1_data_o (r1_data),
    .r2_addr_i (f_rm),
    .r2_en_i   (ctrl.rf_r2_en),
    .r2_data_o (r2_data),
    .w_addr_i  (f_rn),
    .w_en_i    (ctrl.rf_we),
    .w_data_i  (rf_wdata)
  );

  tiny_cpu_alu #(.W(DATA_W)) u_alu (
    .a_i    (r1_data),
    .b_i    (r2_data),
    .sel_i  (ctrl.alu_sel),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  always_comb begin
    unique case (ctrl.rf_src)
      RF_SRC_MEM: rf_wdata = mem_rdata_i;
      RF_SRC_IMM: rf_wdata = lit_zx;
      default:    rf_wdata = alu_y;
    endcase
  end

  always_comb begin
    unique case (ctrl.addr_sel)
      ADDR_DIR: mem_addr_o = lit_zx;
      ADDR_RF:  mem_addr_o = r1_data;
      default:  mem_addr_o = pc_q;
    endcase
  end

  assign mem_wdata_o = ctrl.wd_from_r2 ? r2_data : r1_data;
  assign mem_rd_o    = ctrl.mem_rd;
  assign mem_wr_o    = ctrl.mem_wr;
endmodule

// File: rtl/tiny_cpu_chk.sv
module tiny_cpu_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rd_i,
  input logic         wr_i,
  input logic [W-1:0] addr_i,
  input logic         halted_i,
  input logic [W-1:0] pc_i,
  input logic         pc_inc_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!rd_i && !wr_i && pc_i == '0); // R1
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i)); // R11

  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !$past(rd_i)) |=> (rd_i && $stable(addr_i))); // R2

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_i |=> (pc_i == $past(pc_i) + 1'b1)); // R2

  AST_STORE_THEN_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rd_i); // R5

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> (!rd_i && !wr_i)); // R10

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i); // R10
endmodule

bind tiny_cpu tiny_cpu_chk #(.W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (mem_rd_o),
  .wr_i     (mem_wr_o),
  .addr_i   (mem_addr_o),
  .halted_i (halted_o),
  .pc_i     (pc_q),
  .pc_inc_i (pc_inc)
);

// File: tb/tiny_cpu_bench.sv
module tiny_cpu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 256;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, halted;

  logic [15:0] img     [MEM_WORDS];
  logic [15:0] mem     [MEM_WORDS];
  logic [15:0] ref_mem [MEM_WORDS];
  logic [15:0] ref_rf  [16];

  typedef struct {
    logic        rd;
    logic        wr;
    logic        hlt;
    logic [15:0] addr;
    logic [15:0] wd;
    string       tag;
  } cyc_t;
  cyc_t exp_q[$];

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiny_cpu u_tiny_cpu (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .halted_o    (halted)
  );

  // memory: one-cycle read latency, reloaded from img while in reset
  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= img[i];
      mem_rdata <= '0;
    end else begin
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic rd, input logic wr, input logic hlt,
                      input logic [15:0] addr, input logic [15:0] wd, input string tag);
    cyc_t c;
    c.rd = rd; c.wr = wr; c.hlt = hlt; c.addr = addr; c.wd = wd; c.tag = tag;
    exp_q.push_back(c);
  endtask

  // behavioural instruction model producing the expected port activity per cycle
  task automatic build_trace();
    logic [15:0] pc = '0;
    bit run = 1'b1;
    int n = 0;
    for (int i = 0; i < MEM_WORDS; i++) ref_mem[i] = img[i];
    for (int i = 0; i < 16; i++) ref_rf[i] = '0;
    exp_q.delete();
    while (run && n < 3000) begin
      logic [15:0] ins;
      logic [3:0]  op, rn, rm;
      logic [7:0]  f8;
      ins = ref_mem[pc[7:0]];
      op = ins[15:12]; rn = ins[11:8]; rm = ins[7:4]; f8 = ins[7:0]; // R3 layout
      push(1, 0, 0, pc, 0, "R1/R2 fetch");
      push(1, 0, 0, pc, 0, "R2 fetch hold");
      push(0, 0, 0, 0, 0, "R2/R3 decode");
      pc = pc + 16'd1;
      case (op)
        4'h0: begin
          push(1, 0, 0, {8'h00, f8}, 0, "R4 load");
          push(1, 0, 0, {8'h00, f8}, 0, "R4 load hold");
          ref_rf[rn] = ref_mem[f8];
        end
        4'h1: begin
          push(0, 1, 0, {8'h00, f8}, ref_rf[rn], "R5 store");
          ref_mem[f8] = ref_rf[rn];
        end
        4'h2: begin
          push(0, 1, 0, ref_rf[rn], ref_rf[rm], "R6 indirect store");
          ref_mem[ref_rf[rn][7:0]] = ref_rf[rm];
        end
        4'h3: begin
          push(0, 0, 0, 0, 0, "R7 immediate");
          ref_rf[rn] = {8'h00, f8};
        end
        4'h4: begin
          push(0, 0, 0, 0, 0, "R8 add");
          ref_rf[rn] = ref_rf[rn] + ref_rf[rm];
        end
        4'h5: begin
          push(0, 0, 0, 0, 0, "R8 sub");
          ref_rf[rn] = ref_rf[rn] - ref_rf[rm];
        end
        4'h6: begin
          push(0, 0, 0, 0, 0, "R9 branch");
          if (ref_rf[rn] == 16'd0) pc = pc + {{8{f8[7]}}, f8};
        end
        default: begin
          for (int k = 0; k < 8; k++) push(0, 0, 1, 0, 0, "R10 stopped");
          run = 1'b0;
        end
      endcase
      n++;
    end
  endtask

  task automatic run_program();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset rd", {31'd0, mem_rd}, 32'd0);
    check("R1 reset wr", {31'd0, mem_wr}, 32'd0);
    check("R1 reset halted", {31'd0, halted}, 32'd0);
    build_trace();
    rst_ni = 1'b1;
    while (exp_q.size() > 0) begin
      cyc_t c;
      @(negedge clk);
      c = exp_q.pop_front();
      check("R11 strobes exclusive", {31'd0, mem_rd & mem_wr}, 32'd0);
      check({c.tag, " strobes"}, {29'd0, mem_rd, mem_wr, halted}, {29'd0, c.rd, c.wr, c.hlt});
      if (c.rd || c.wr) check({c.tag, " address"}, {16'd0, mem_addr}, {16'd0, c.addr});
      if (c.wr)         check({c.tag, " data"}, {16'd0, mem_wdata}, {16'd0, c.wd});
    end
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    // program A: sum 10..1, stores, indirect store, wrap, opcode 7 stop
    for (int i = 0; i < MEM_WORDS; i++) img[i] = '0;
    img[0]  = 16'h3000; // r0 = 0
    img[1]  = 16'h310A; // r1 = 10
    img[2]  = 16'h3201; // r2 = 1
    img[3]  = 16'h3300; // r3 = 0
    img[4]  = 16'h6103; // branch to 8 when r1 == 0
    img[5]  = 16'h4010; // r0 += r1
    img[6]  = 16'h5120; // r1 -= r2
    img[7]  = 16'h63FC; // always back to 4
    img[8]  = 16'h1080; // M[80] = r0
    img[9]  = 16'h3582; // r5 = 0x82
    img[10] = 16'h0481; // r4 = M[81]
    img[11] = 16'h2540; // M[r5] = r4
    img[12] = 16'h3600; // r6 = 0
    img[13] = 16'h5620; // r6 -= r2 -> wraps
    img[14] = 16'h1683; // M[83] = r6
    img[15] = 16'h7000; // lowest unused opcode
    img[16] = 16'h1080; // never reached
    img[8'h81] = 16'h1234;
    run_program();
    check("R9 loop sum", {16'd0, mem[8'h80]}, 32'h0037);
    check("R4/R6 copied word", {16'd0, mem[8'h82]}, 32'h1234);
    check("R8 sub wrap", {16'd0, mem[8'h83]}, 32'hFFFF);
    check("R10 halted held", {31'd0, halted}, 32'd1);
    check("R10 no store after stop", {16'd0, mem[8'h80]}, 32'h0037);

    // program B: branch not taken, add, immediate zero-extend, opcode 15 stop
    for (int i = 0; i < MEM_WORDS; i++) img[i] = '0;
    img[0] = 16'h3A05; // r10 = 5
    img[1] = 16'h6A7F; // not taken
    img[2] = 16'h4AA0; // r10 += r10
    img[3] = 16'h1A90; // M[90] = r10
    img[4] = 16'h3BFF; // r11 = 0x00FF
    img[5] = 16'h1B91; // M[91] = r11
    img[6] = 16'hF123; // highest unused opcode
    run_program();
    check("R8/R9 add after untaken branch", {16'd0, mem[8'h90]}, 32'h000A);
    check("R7 immediate zero-extended", {16'd0, mem[8'h91]}, 32'h00FF);
    check("R10 halted held", {31'd0, halted}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule